// File: doc/BRIEF.md
# Register Stack Frame Manager

This block keeps track of a windowed register stack used across procedure calls. Logical register numbers from 32 upward are renamed onto a circular physical file of stacked entries; numbers 0 to 31 address a separate fixed bank that is never renamed. A current frame marker holds the total frame size and the size of its local part. The output part is whatever remains above the locals. One saved copy of the marker is kept for the caller.

Three commands act on the frame. A resize command sets the local size and the frame size from three immediates. A call command shifts the rename base so that the caller's first output register becomes register 32 of the callee. A return command undoes the call. Two combinational read ports and one write port are checked against the current frame on every access. Moving frames out to memory is not done here; an overflow flag reports when the live frames no longer fit in the physical file.

Top module: `rsf_frame_mgr`

## Requirements
- R1: While `rst_n` is low at a clock edge, the frame size, local size and rename base become zero, and `fault_illegal` and `overflow` are low after that edge.
- R2: A resize (`cmd_op` = 1 with `cmd_valid`) with immediates in, loc and out sets the local size to in+loc and the frame size to in+loc+out, both visible after the next clock edge.
- R3: A resize whose frame size would exceed 96 leaves both sizes unchanged and pulses `fault_illegal` high for the cycle after the edge.
- R4: A call (`cmd_op` = 2) saves the current marker, sets the local size to zero and the frame size to the caller's frame size minus its local size, and advances the base by the caller's local size, so that caller register 32+sol is read as register 32 by the callee.
- R5: A return (`cmd_op` = 3) reloads both sizes from the saved marker and moves the base back by the saved local size, restoring the caller's view of every register.
- R6: A resize never moves the rename base: a register inside the frame reads the same value before and after it.
- R7: A write to register 32+k with k not below the frame size changes no storage and pulses `fault_illegal` high for the cycle after the edge; a cycle with no command and no such write leaves `fault_illegal` low.
- R8: A read of register 32+k with k not below the frame size returns zero.
- R9: `overflow` is high exactly when the sum of the local sizes of all callers still active plus the current frame size exceeds 64.
- R10: Registers 0 to 31 read back the last value written to them, whatever calls, returns and resizes happened.
- R11: Register 32+k maps to physical entry (base + k) modulo 64, so frames wrap around the end of the physical file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 2 | 0 none, 1 resize, 2 call, 3 return |
| imm_in | input | 7 | Resize: input register count |
| imm_loc | input | 7 | Resize: local register count |
| imm_out | input | 7 | Resize: output register count |
| rd0_addr | input | 7 | Read port 0 logical register number |
| rd0_data | output | 32 | Read port 0 data, zero outside the frame |
| rd1_addr | input | 7 | Read port 1 logical register number |
| rd1_data | output | 32 | Read port 1 data, zero outside the frame |
| wr_en | input | 1 | Write port enable |
| wr_addr | input | 7 | Write port logical register number |
| wr_data | input | 32 | Write port data |
| cur_sof | output | 7 | Current total frame size |
| cur_sol | output | 7 | Current local area size |
| fault_illegal | output | 1 | Registered pulse: illegal write or rejected resize |
| overflow | output | 1 | Live frames exceed the physical file |

## Verification
The assertions watch, every cycle, that the local size never exceeds the frame size, that a call zeroes the locals and shrinks the frame to the old output area, that out-of-frame reads come back as zero, that out-of-frame writes and oversized resizes raise the fault while oversized resizes keep the marker, and that no fault appears on an idle cycle. Whether the renaming is right, in the sense that the callee sees the caller's outputs, a return restores the caller's registers, a suppressed write really left storage alone and the base wraps modulo 64, only shows through the data values the bench writes and later reads back across call, resize and return sequences.

// File: rtl/rsf_pkg.sv
// Shared types for the register stack frame manager.
// Assumes frame sizes fit in FRM_W bits (at most 127).
package rsf_pkg;
    localparam int FRM_W = 7;

    typedef enum logic [1:0] {
        FOP_NONE   = 2'd0,
        FOP_RESIZE = 2'd1,
        FOP_CALL   = 2'd2,
        FOP_RETURN = 2'd3
    } frame_op_e;

    typedef struct packed {
        logic [FRM_W-1:0] sof;
        logic [FRM_W-1:0] sol;
    } frame_mark_t;
endpackage

// File: rtl/rsf_marker.sv
// Frame marker state: current marker, one saved marker, rename base and
// the running count of caller locals used for the overflow flag.
// Assumes PHYS_DEPTH is a power of two so the base wraps by truncation.
module rsf_marker
    import rsf_pkg::*;
#(
    parameter int PHYS_DEPTH = 64,
    parameter int MAX_FRAME  = 96,
    parameter int IMM_W      = 7,
    parameter int USED_W     = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cmd_valid,
    input  frame_op_e                     cmd_op,
    input  logic [IMM_W-1:0]              imm_in,
    input  logic [IMM_W-1:0]              imm_loc,
    input  logic [IMM_W-1:0]              imm_out,
    output frame_mark_t                   cfm,
    output logic [$clog2(PHYS_DEPTH)-1:0] base,
    output logic                          reject,
    output logic                          overflow
);
    localparam int PIDX_W = $clog2(PHYS_DEPTH);
    localparam int SUM_W  = IMM_W + 2;
    localparam int UEXT_W = USED_W + 1;
    localparam logic [USED_W-1:0] USED_MAX = '1;

    frame_mark_t          pfm;
    logic [USED_W-1:0]    used;
    logic [SUM_W-1:0]     sum_loc;
    logic [SUM_W-1:0]     sum_all;
    logic                 is_resize;
    logic                 is_call;
    logic                 is_ret;
    logic [FRM_W-1:0]     out_size;
    logic [PIDX_W-1:0]    base_fwd;
    logic [PIDX_W-1:0]    base_back;
    logic [UEXT_W-1:0]    used_add;
    logic [USED_W-1:0]    used_up;
    logic [USED_W-1:0]    used_down;
    logic [UEXT_W-1:0]    live_total;

    // Decode the command and size the requested frame.
    always_comb begin
        is_resize = cmd_valid && (cmd_op == FOP_RESIZE);
        is_call   = cmd_valid && (cmd_op == FOP_CALL);
        is_ret    = cmd_valid && (cmd_op == FOP_RETURN);
        sum_loc   = SUM_W'(imm_in) + SUM_W'(imm_loc);
        sum_all   = sum_loc + SUM_W'(imm_out);
        reject    = is_resize &&
                    ((sum_all > SUM_W'(MAX_FRAME)) || (sum_loc > sum_all));
        out_size  = cfm.sof - cfm.sol;
    end

    // Next base values for call and return, modulo the physical depth.
    always_comb begin
        base_fwd  = base + PIDX_W'(cfm.sol);
        base_back = base - PIDX_W'(pfm.sol);
    end

    // Saturating bookkeeping of caller locals still held in the file.
    always_comb begin
        used_add  = UEXT_W'(used) + UEXT_W'(cfm.sol);
        used_up   = used_add[USED_W] ? USED_MAX : used_add[USED_W-1:0];
        used_down = (used >= USED_W'(pfm.sol)) ? (used - USED_W'(pfm.sol)) : '0;
    end

    // Overflow when live caller locals plus the current frame exceed the file.
    always_comb begin
        live_total = UEXT_W'(used) + UEXT_W'(cfm.sof);
        overflow   = live_total > UEXT_W'(PHYS_DEPTH);
    end

    // Current and saved markers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfm <= '0;
            pfm <= '0;
        end else if (is_resize && !reject) begin
            cfm.sol <= FRM_W'(sum_loc);
            cfm.sof <= FRM_W'(sum_all);
        end else if (is_call) begin
            pfm     <= cfm;
            cfm.sol <= '0;
            cfm.sof <= out_size;
        end else if (is_ret) begin
            cfm <= pfm;
        end
    end

    // Rename base; a resize never touches it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base <= '0;
        end else if (is_call) begin
            base <= base_fwd;
        end else if (is_ret) begin
            base <= base_back;
        end
    end

    // Caller locals count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used <= '0;
        end else if (is_call) begin
            used <= used_up;
        end else if (is_ret) begin
            used <= used_down;
        end
    end
endmodule

// File: rtl/rsf_rename.sv
// Renames one logical register number to a bank index and checks it
// against the current frame. Purely combinational.
// Assumes PHYS_DEPTH is a power of two and STATIC_REGS is a power of two.
module rsf_rename
    import rsf_pkg::*;
#(
    parameter int STATIC_REGS = 32,
    parameter int PHYS_DEPTH  = 64,
    parameter int REG_AW      = 7
) (
    input  logic [REG_AW-1:0]              addr,
    input  logic [$clog2(PHYS_DEPTH)-1:0]  base,
    input  logic [FRM_W-1:0]               sof,
    output logic                           stacked,
    output logic                           in_frame,
    output logic [$clog2(PHYS_DEPTH)-1:0]  pidx,
    output logic [$clog2(STATIC_REGS)-1:0] sidx
);
    localparam int PIDX_W = $clog2(PHYS_DEPTH);
    localparam int SIDX_W = $clog2(STATIC_REGS);
    localparam int CMP_W  = ((REG_AW > FRM_W) ? REG_AW : FRM_W) + 1;

    logic [REG_AW-1:0] off;

    // Offset into the stacked area and bound check.
    always_comb begin
        stacked  = addr >= REG_AW'(STATIC_REGS);
        off      = addr - REG_AW'(STATIC_REGS);
        in_frame = !stacked || (CMP_W'(off) < CMP_W'(sof));
        pidx     = base + PIDX_W'(off);
        sidx     = addr[SIDX_W-1:0];
    end
endmodule

// File: rtl/rsf_regfile.sv
// Storage: a fixed bank and a circular stacked bank, one write port and
// NRD combinational read ports. Out-of-frame reads return zero.
// Assumes the caller has already bounded and renamed every index.
module rsf_regfile #(
    parameter int DATA_W      = 32,
    parameter int STATIC_REGS = 32,
    parameter int PHYS_DEPTH  = 64,
    parameter int NRD         = 2
) (
    input  logic                                      clk,
    input  logic                                      we_static,
    input  logic                                      we_stack,
    input  logic [$clog2(STATIC_REGS)-1:0]            w_sidx,
    input  logic [$clog2(PHYS_DEPTH)-1:0]             w_pidx,
    input  logic [DATA_W-1:0]                         w_data,
    input  logic [NRD-1:0]                            r_stacked,
    input  logic [NRD-1:0]                            r_ok,
    input  logic [NRD-1:0][$clog2(STATIC_REGS)-1:0]   r_sidx,
    input  logic [NRD-1:0][$clog2(PHYS_DEPTH)-1:0]    r_pidx,
    output logic [NRD-1:0][DATA_W-1:0]                r_data
);
    logic [DATA_W-1:0] fixed_bank [STATIC_REGS];
    logic [DATA_W-1:0] stack_bank [PHYS_DEPTH];

    // Fixed bank write.
    always_ff @(posedge clk) begin
        if (we_static) begin
            fixed_bank[w_sidx] <= w_data;
        end
    end

    // Stacked bank write.
    always_ff @(posedge clk) begin
        if (we_stack) begin
            stack_bank[w_pidx] <= w_data;
        end
    end

    // Read ports.
    for (genvar g = 0; g < NRD; g++) begin : g_rd
        always_comb begin
            if (!r_ok[g]) begin
                r_data[g] = '0;
            end else if (r_stacked[g]) begin
                r_data[g] = stack_bank[r_pidx[g]];
            end else begin
                r_data[g] = fixed_bank[r_sidx[g]];
            end
        end
    end
endmodule

// File: rtl/rsf_frame_mgr.sv
// Top of the register stack frame manager. Takes resize, call and return
// commands, renames two read ports and one write port through the current
// frame, and flags illegal writes, rejected resizes and physical overflow.
// Assumes commands and the write port act on the state before the edge.
module rsf_frame_mgr
    import rsf_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int PHYS_DEPTH  = 64,
    parameter int MAX_FRAME   = 96,
    parameter int STATIC_REGS = 32,
    parameter int REG_AW      = 7,
    parameter int IMM_W       = 7,
    parameter int USED_W      = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [IMM_W-1:0]  imm_in,
    input  logic [IMM_W-1:0]  imm_loc,
    input  logic [IMM_W-1:0]  imm_out,
    input  logic [REG_AW-1:0] rd0_addr,
    output logic [DATA_W-1:0] rd0_data,
    input  logic [REG_AW-1:0] rd1_addr,
    output logic [DATA_W-1:0] rd1_data,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [FRM_W-1:0]  cur_sof,
    output logic [FRM_W-1:0]  cur_sol,
    output logic              fault_illegal,
    output logic              overflow
);
    localparam int PIDX_W = $clog2(PHYS_DEPTH);
    localparam int SIDX_W = $clog2(STATIC_REGS);
    localparam int NRD    = 2;
    localparam int NPORT  = NRD + 1;
    localparam int WPORT  = NRD;

    frame_mark_t                  cfm;
    logic [PIDX_W-1:0]            base;
    logic                         reject;
    logic                         wr_bad;

    logic [NPORT-1:0][REG_AW-1:0] p_addr;
    logic [NPORT-1:0]             p_stacked;
    logic [NPORT-1:0]             p_ok;
    logic [NPORT-1:0][PIDX_W-1:0] p_pidx;
    logic [NPORT-1:0][SIDX_W-1:0] p_sidx;
    logic [NRD-1:0][DATA_W-1:0]   r_data;

    rsf_marker #(
        .PHYS_DEPTH (PHYS_DEPTH),
        .MAX_FRAME  (MAX_FRAME),
        .IMM_W      (IMM_W),
        .USED_W     (USED_W)
    ) u_marker (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (frame_op_e'(cmd_op)),
        .imm_in    (imm_in),
        .imm_loc   (imm_loc),
        .imm_out   (imm_out),
        .cfm       (cfm),
        .base      (base),
        .reject    (reject),
        .overflow  (overflow)
    );

    // Gather the port addresses: reads first, the write port last.
    always_comb begin
        p_addr[0]     = rd0_addr;
        p_addr[1]     = rd1_addr;
        p_addr[WPORT] = wr_addr;
    end

    for (genvar g = 0; g < NPORT; g++) begin : g_ren
        rsf_rename #(
            .STATIC_REGS (STATIC_REGS),
            .PHYS_DEPTH  (PHYS_DEPTH),
            .REG_AW      (REG_AW)
        ) u_ren (
            .addr     (p_addr[g]),
            .base     (base),
            .sof      (cfm.sof),
            .stacked  (p_stacked[g]),
            .in_frame (p_ok[g]),
            .pidx     (p_pidx[g]),
            .sidx     (p_sidx[g])
        );
    end

    rsf_regfile #(
        .DATA_W      (DATA_W),
        .STATIC_REGS (STATIC_REGS),
        .PHYS_DEPTH  (PHYS_DEPTH),
        .NRD         (NRD)
    ) u_rf (
        .clk       (clk),
        .we_static (wr_en && !p_stacked[WPORT]),
        .we_stack  (wr_en && p_stacked[WPORT] && p_ok[WPORT]),
        .w_sidx    (p_sidx[WPORT]),
        .w_pidx    (p_pidx[WPORT]),
        .w_data    (wr_data),
        .r_stacked (p_stacked[NRD-1:0]),
        .r_ok      (p_ok[NRD-1:0]),
        .r_sidx    (p_sidx[NRD-1:0]),
        .r_pidx    (p_pidx[NRD-1:0]),
        .r_data    (r_data)
    );

    // Illegal write detection on the write port.
    always_comb begin
        wr_bad = wr_en && !p_ok[WPORT];
    end

    // Registered fault pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_illegal <= 1'b0;
        end else begin
            fault_illegal <= wr_bad || reject;
        end
    end

    // Drive outputs.
    always_comb begin
        rd0_data = r_data[0];
        rd1_data = r_data[1];
        cur_sof  = cfm.sof;
        cur_sol  = cfm.sol;
    end
endmodule

// File: rtl/rsf_frame_mgr_chk.sv
// Property checker for rsf_frame_mgr, attached by bind below.
module rsf_frame_mgr_chk #(
    parameter int DATA_W      = 32,
    parameter int PHYS_DEPTH  = 64,
    parameter int MAX_FRAME   = 96,
    parameter int STATIC_REGS = 32,
    parameter int REG_AW      = 7,
    parameter int IMM_W       = 7,
    parameter int FW          = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [1:0]        cmd_op,
    input logic [IMM_W-1:0]  imm_in,
    input logic [IMM_W-1:0]  imm_loc,
    input logic [IMM_W-1:0]  imm_out,
    input logic [REG_AW-1:0] rd0_addr,
    input logic [DATA_W-1:0] rd0_data,
    input logic              wr_en,
    input logic [REG_AW-1:0] wr_addr,
    input logic [FW-1:0]     cur_sof,
    input logic [FW-1:0]     cur_sol,
    input logic              fault_illegal,
    input logic              overflow
);
    int  req_sum;
    logic rd0_oof;
    logic wr_oof;
    logic big_resize;

    always_comb begin
        req_sum    = int'(imm_in) + int'(imm_loc) + int'(imm_out);
        big_resize = cmd_valid && (cmd_op == 2'd1) && (req_sum > MAX_FRAME);
        rd0_oof    = (int'(rd0_addr) >= STATIC_REGS) &&
                     ((int'(rd0_addr) - STATIC_REGS) >= int'(cur_sof));
        wr_oof     = wr_en && (int'(wr_addr) >= STATIC_REGS) &&
                     ((int'(wr_addr) - STATIC_REGS) >= int'(cur_sof));
    end

    AST_SPLIT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        cur_sol <= cur_sof); // R2
    AST_REJECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        big_resize |=> fault_illegal && $stable(cur_sof) && $stable(cur_sol)); // R3
    AST_CALL_ZERO_LOCALS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd2) |=> cur_sol == '0); // R4
    AST_CALL_OUT_AREA: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd2) |=> cur_sof == $past(cur_sof - cur_sol)); // R4
    AST_BAD_WRITE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_oof |=> fault_illegal); // R7
    AST_IDLE_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid && !wr_en) |=> !fault_illegal); // R7
    AST_OOF_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd0_oof |-> rd0_data == '0); // R8
    AST_BIG_FRAME_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cur_sof) > PHYS_DEPTH) |-> overflow); // R9
endmodule

bind rsf_frame_mgr rsf_frame_mgr_chk #(
    .DATA_W      (DATA_W),
    .PHYS_DEPTH  (PHYS_DEPTH),
    .MAX_FRAME   (MAX_FRAME),
    .STATIC_REGS (STATIC_REGS),
    .REG_AW      (REG_AW),
    .IMM_W       (IMM_W),
    .FW          (rsf_pkg::FRM_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_op        (cmd_op),
    .imm_in        (imm_in),
    .imm_loc       (imm_loc),
    .imm_out       (imm_out),
    .rd0_addr      (rd0_addr),
    .rd0_data      (rd0_data),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .cur_sof       (cur_sof),
    .cur_sol       (cur_sol),
    .fault_illegal (fault_illegal),
    .overflow      (overflow)
);

// File: tb/sim_rsf_frame_mgr.sv
// Bench: directed corner cases then seeded random commands and accesses,
// all compared against a behavioural model held in the bench.
module sim_rsf_frame_mgr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [6:0]  imm_in = '0, imm_loc = '0, imm_out = '0;
    logic [6:0]  rd0_addr = '0, rd1_addr = '0, wr_addr = '0;
    logic [31:0] rd0_data, rd1_data, wr_data = '0;
    logic        wr_en = 1'b0;
    logic [6:0]  cur_sof, cur_sol;
    logic        fault_illegal, overflow;

    int checks = 0;
    int errors = 0;

    // Model state
    logic [31:0] m_stk [64];
    logic [31:0] m_stat [32];
    int m_sof = 0, m_sol = 0, m_base = 0, m_used = 0;
    int p_sof = 0, p_sol = 0;
    logic exp_fault = 1'b0;

    always #5 clk = ~clk;

    rsf_frame_mgr u0 (
        .clk (clk), .rst_n (rst_n), .cmd_valid (cmd_valid), .cmd_op (cmd_op),
        .imm_in (imm_in), .imm_loc (imm_loc), .imm_out (imm_out),
        .rd0_addr (rd0_addr), .rd0_data (rd0_data),
        .rd1_addr (rd1_addr), .rd1_data (rd1_data),
        .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
        .cur_sof (cur_sof), .cur_sol (cur_sol),
        .fault_illegal (fault_illegal), .overflow (overflow)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mread(input int a);
        if (a < 32) return m_stat[a];
        if (a - 32 >= m_sof) return 32'd0;
        return m_stk[(m_base + a - 32) % 64];
    endfunction

    // One cycle: drive at the falling edge, check reads, update model,
    // then check the marker outputs after the rising edge.
    task automatic step(input string req, input int op, input int ii, input int il,
                        input int io, input int a0, input int a1, input logic we,
                        input int wa, input logic [31:0] wd);
        int sl, sf;
        cmd_valid = (op != 0);
        cmd_op    = 2'(op);
        imm_in    = 7'(ii); imm_loc = 7'(il); imm_out = 7'(io);
        rd0_addr  = 7'(a0); rd1_addr = 7'(a1);
        wr_en     = we; wr_addr = 7'(wa); wr_data = wd;
        #1;
        check({req, " rd0"}, rd0_data, mread(a0));
        check({req, " rd1"}, rd1_data, mread(a1));
        exp_fault = 1'b0;
        if (we) begin
            if (wa < 32) m_stat[wa] = wd;
            else if (wa - 32 < m_sof) m_stk[(m_base + wa - 32) % 64] = wd;
            else exp_fault = 1'b1;
        end
        case (op)
            1: begin
                sl = ii + il; sf = sl + io;
                if (sf > 96) exp_fault = 1'b1;
                else begin m_sol = sl; m_sof = sf; end
            end
            2: begin
                p_sof = m_sof; p_sol = m_sol;
                m_base = (m_base + m_sol) % 64;
                m_used = m_used + m_sol;
                m_sof = m_sof - m_sol; m_sol = 0;
            end
            3: begin
                m_sof = p_sof; m_sol = p_sol;
                m_base = (m_base + 128 - p_sol) % 64;
                m_used = (m_used >= p_sol) ? m_used - p_sol : 0;
            end
            default: ;
        endcase
        @(posedge clk);
        @(negedge clk);
        check({req, " sof"}, 32'(cur_sof), 32'(m_sof));
        check({req, " sol"}, 32'(cur_sol), 32'(m_sol));
        check({req, " fault"}, 32'(fault_illegal), 32'(exp_fault));
        check({req, " overflow R9"}, 32'(overflow), 32'(m_used + m_sof > 64));
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd2718);
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 sof", 32'(cur_sof), 0);
        check("R1 sol", 32'(cur_sol), 0);
        check("R1 fault", 32'(fault_illegal), 0);
        check("R1 overflow", 32'(overflow), 0);
        rst_n = 1'b1;
        // R8: frame is empty, so stacked reads are zero
        step("R8", 0, 0, 0, 0, 32, 40, 1'b0, 0, 0);
        // R2: open a 64-entry frame and fill every register
        step("R2", 1, 0, 64, 0, 0, 0, 1'b0, 0, 0);
        for (int i = 0; i < 64; i++) step("R2 fill", 0, 0, 0, 0, 32, 0, 1'b1, 32 + i, 32'h1000 + i);
        for (int i = 0; i < 32; i++) step("R10 fill", 0, 0, 0, 0, 32, 0, 1'b1, i, 32'h2000 + i);
        // R2 and R6: resize keeps the mapping
        step("R2", 1, 2, 3, 4, 32, 36, 1'b0, 0, 0);
        step("R6", 0, 0, 0, 0, 32, 40, 1'b0, 0, 0);
        check("R6 r32", rd0_data, 32'h1000);
        // R3: oversized resize rejected
        step("R3", 1, 60, 30, 10, 32, 33, 1'b0, 0, 0);
        // R4: call; callee r32 is caller r37
        step("R4", 2, 0, 0, 0, 32, 35, 1'b0, 0, 0);
        step("R4 view", 0, 0, 0, 0, 32, 35, 1'b0, 0, 0);
        check("R4 r32", rd0_data, 32'h1005);
        check("R4 r35", rd1_data, 32'h1008);
        // R7 and R8: write beyond frame faults and is suppressed
        step("R7", 0, 0, 0, 0, 36, 5, 1'b1, 36, 32'hDEAD);
        check("R8 r36", rd0_data, 0);
        check("R10 r5", rd1_data, 32'h2005);
        step("R7 grow", 1, 0, 8, 0, 36, 32, 1'b0, 0, 0);
        step("R7 kept", 0, 0, 0, 0, 36, 32, 1'b0, 0, 0);
        check("R7 r36", rd0_data, 32'h1009);
        // R5: return restores the caller
        step("R5", 3, 0, 0, 0, 32, 36, 1'b0, 0, 0);
        step("R5 view", 0, 0, 0, 0, 32, 36, 1'b0, 0, 0);
        check("R5 r32", rd0_data, 32'h1000);
        check("R5 sof", 32'(cur_sof), 9);
        // R11: wrap around the physical file
        step("R11", 1, 0, 60, 4, 32, 33, 1'b0, 0, 0);
        step("R11 call", 2, 0, 0, 0, 32, 35, 1'b0, 0, 0);
        step("R11 grow", 1, 0, 8, 0, 32, 35, 1'b0, 0, 0);
        step("R11 view", 0, 0, 0, 0, 35, 36, 1'b0, 0, 0);
        check("R11 r35", rd0_data, 32'h103F);
        check("R11 r36", rd1_data, 32'h1000);
        step("R11 ret", 3, 0, 0, 0, 32, 33, 1'b0, 0, 0);
        // R9: overflow from a single frame and from live caller locals
        step("R9 big", 1, 0, 90, 6, 32, 33, 1'b0, 0, 0);
        check("R9 big", 32'(overflow), 1);
        step("R9 fit", 1, 0, 40, 20, 32, 33, 1'b0, 0, 0);
        step("R9 call", 2, 0, 0, 0, 32, 33, 1'b0, 0, 0);
        step("R9 grow", 1, 0, 30, 0, 32, 33, 1'b0, 0, 0);
        check("R9 nest", 32'(overflow), 1);
        step("R9 ret", 3, 0, 0, 0, 32, 33, 1'b0, 0, 0);
        // Random phase
        for (int n = 0; n < 3000; n++) begin
            int r, op, a0, a1, wa;
            r  = $urandom % 16;
            op = 0;
            if (r < 2) op = 1;
            else if (r == 2) op = (m_used < 150) ? 2 : 3;
            else if (r == 3) op = 3;
            a0 = ($urandom % 4 == 0) ? int'($urandom % 128) : 32 + int'($urandom % (m_sof + 4));
            a1 = int'($urandom % 128);
            wa = ($urandom % 3 == 0) ? int'($urandom % 128) : 32 + int'($urandom % (m_sof + 2));
            if (wa > 127) wa = 127;
            if (a0 > 127) a0 = 127;
            step("R11 rand", op, int'($urandom % 40), int'($urandom % 40), int'($urandom % 40),
                 a0, a1, 1'($urandom % 2), wa, $urandom);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule